// File: doc/BRIEF.md
# Bus Response Timing Monitor

This block watches a 10 Mbit/s dual-redundant serial command/response bus from the bus controller or monitor side and times its two key intervals: the terminal response time and the intermessage gap. It does not decode the line itself. A Manchester decoder upstream supplies single-cycle strobes marking the middle of each word's parity bit and the middle of each word's sync. With each strobe comes a qualifier that tells the monitor what the word means for timing. Every interval is counted in clock ticks from a mid-parity strobe to the following mid-sync strobe.

A parity strobe marked "reply due" arms a response measurement. A parity strobe marked "message end" arms a gap measurement. The next command/status-type sync closes the measurement. The monitor then reports the tick count and a 2-bit verdict as a one-cycle result. If a response takes too long, the monitor produces a no-response verdict at the timeout instead. Four sticky error flags collect short gaps, early responses, late responses and missing responses until they are cleared. All thresholds are parameters in ticks. The defaults assume a 100 MHz clock: a 1 µs gap, a 0.4 to 4 µs response window and an 8 µs timeout. `NORESP_TK` must stay below `2**TICK_W - 1`.

Top module: `bus_resp_timer`

## Requirements
- R1: While `rst_n` is low, `res_valid_o`, `res_code_o`, `res_gap_o`, `res_ticks_o` and `err_flags_o` are all zero.
- R2: The interval N is the number of rising clock edges from the one that samples `par_mid_i` to the one that samples the closing `sync_mid_i`. The result appears on `res_ticks_o` with `res_valid_o` high for exactly one cycle, directly after the closing edge.
- R3: A response measurement is armed by a parity strobe with `reply_due_i`=1 and closed by a sync strobe with `sync_cmd_i`=1. It reports `res_gap_o`=0 and one of three codes: 1 (early) if N < `RESP_MIN_TK`, 0 (ok) if `RESP_MIN_TK` ≤ N ≤ `RESP_MAX_TK`, and 2 (late) if `RESP_MAX_TK` < N ≤ `NORESP_TK`.
- R4: If an armed response measurement sees no command/status sync by N = `NORESP_TK`, the monitor reports code 3 (no response) with `res_ticks_o` = `NORESP_TK` and `res_gap_o`=0. This result has the same latency as a sync at that tick. A sync exactly at `NORESP_TK` counts as late.
- R5: A gap measurement is armed by a parity strobe with `msg_end_i`=1 (and `reply_due_i`=0) and closed by the next command sync. It reports `res_gap_o`=1 and code 1 if N < `GAP_MIN_TK`, or code 0 otherwise.
- R6: `err_flags_o` holds four sticky flags. Bit 0 is a short gap, bit 1 an early response, bit 2 a late response and bit 3 no response. Each bit is set by the matching result in the same cycle as its `res_valid_o` pulse. A bit stays set until it is cleared.
- R7: A one-cycle `clr_i` clears all flags from the next cycle on. A flag set in the same cycle as a clear takes precedence over the clear.
- R8: Every parity strobe restarts the count. A pending measurement that is overtaken this way is dropped without a result. A parity strobe with neither qualifier arms nothing, so no later sync or timeout produces a result.
- R9: A sync strobe with `sync_cmd_i`=0 (a data word) neither closes nor disturbs a pending measurement.
- R10: The count saturates at 2**`TICK_W`-1. A longer gap reports that value with code 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock; one tick of resolution |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr_i | input | 1 | Clears the sticky error flags |
| par_mid_i | input | 1 | Strobe at the middle of a word's parity bit |
| reply_due_i | input | 1 | Qualifies par_mid_i: a terminal reply is expected |
| msg_end_i | input | 1 | Qualifies par_mid_i: the word closes a message |
| sync_mid_i | input | 1 | Strobe at the middle of a word's sync |
| sync_cmd_i | input | 1 | Qualifies sync_mid_i: command/status-type sync |
| res_valid_o | output | 1 | One-cycle result strobe |
| res_code_o | output | 2 | 0 ok, 1 early/short, 2 late, 3 no response |
| res_gap_o | output | 1 | 1 = result is a gap, 0 = a response time |
| res_ticks_o | output | TICK_W | Measured interval in ticks |
| err_flags_o | output | 4 | Sticky flags: short gap, early, late, no response |

## Verification
A sync sampled on edge P+N, where P is the edge that samples the parity strobe, produces a result visible right after edge P+N. A timeout appears right after edge P+`NORESP_TK`. The flags update on the same edge as the result, and a clear takes effect one edge later. The bench drives inputs on falling edges, so it can count falling edges from the parity strobe to place each sync on an exact tick. It then samples the result and flags at the next falling edge, and checks at the falling edge after that that the valid strobe has dropped.

// File: rtl/brtm_pkg.sv
package brtm_pkg;

  typedef enum logic [1:0] {
    RC_OK     = 2'd0,
    RC_EARLY  = 2'd1,
    RC_LATE   = 2'd2,
    RC_NORESP = 2'd3
  } rc_e;

  typedef enum logic [1:0] {
    ARM_IDLE = 2'd0,
    ARM_RESP = 2'd1,
    ARM_GAP  = 2'd2
  } arm_e;

  localparam int FLAG_N      = 4;
  localparam int FL_GAP      = 0;
  localparam int FL_EARLY    = 1;
  localparam int FL_LATE     = 2;
  localparam int FL_NORESP   = 3;

endpackage

// File: rtl/brtm_tick_counter.sv
module brtm_tick_counter #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         restart_i,
  input  logic         run_i,
  output logic [W-1:0] cnt_o
);

  localparam logic [W-1:0] CNT_MAX = '1;
  localparam logic [W-1:0] CNT_ONE = W'(1);

  logic [W-1:0] cnt_q;
  logic [W-1:0] cnt_d;
  logic         cnt_en;

  always_comb begin
    cnt_en = 1'b0;
    cnt_d  = cnt_q;
    if (restart_i) begin
      cnt_en = 1'b1;
      cnt_d  = CNT_ONE;
    end else if (run_i && (cnt_q != CNT_MAX)) begin
      cnt_en = 1'b1;
      cnt_d  = cnt_q + CNT_ONE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign cnt_o = cnt_q;

  AST_CNT_RESTART: assert property (@(posedge clk) disable iff (!rst_n) restart_i |=> (cnt_q == CNT_ONE)); // R8
  AST_CNT_SATURATE: assert property (@(posedge clk) disable iff (!rst_n) ((cnt_q == CNT_MAX) && !restart_i) |=> (cnt_q == CNT_MAX)); // R10

endmodule

// File: rtl/brtm_window_class.sv
module brtm_window_class
  import brtm_pkg::*;
#(
  parameter int W           = 12,
  parameter int GAP_MIN_TK  = 100,
  parameter int RESP_MIN_TK = 40,
  parameter int RESP_MAX_TK = 400
) (
  input  logic [W-1:0] ticks_i,
  input  logic         gap_i,
  output rc_e          code_o
);

  localparam logic [W-1:0] GAP_MIN_V  = W'(GAP_MIN_TK);
  localparam logic [W-1:0] RESP_MIN_V = W'(RESP_MIN_TK);
  localparam logic [W-1:0] RESP_MAX_V = W'(RESP_MAX_TK);

  always_comb begin
    code_o = RC_OK;
    if (gap_i) begin
      if (ticks_i < GAP_MIN_V) code_o = RC_EARLY;
    end else begin
      if (ticks_i < RESP_MIN_V)      code_o = RC_EARLY;
      else if (ticks_i > RESP_MAX_V) code_o = RC_LATE;
    end
  end

endmodule

// File: rtl/brtm_sticky_flags.sv
module brtm_sticky_flags #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr_i,
  input  logic [N-1:0] set_i,
  output logic [N-1:0] flag_o
);

  logic [N-1:0] flag_q;
  logic [N-1:0] flag_d;

  for (genvar i = 0; i < N; i++) begin : g_flag
    always_comb begin
      if (set_i[i])   flag_d[i] = 1'b1;
      else if (clr_i) flag_d[i] = 1'b0;
      else            flag_d[i] = flag_q[i];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        flag_q[i] <= 1'b0;
      end else begin
        flag_q[i] <= flag_d[i];
      end
    end

    AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (flag_q[i] && !clr_i) |=> flag_q[i]); // R6
    AST_FLAG_CLEAR: assert property (@(posedge clk) disable iff (!rst_n) (clr_i && !set_i[i]) |=> !flag_q[i]); // R7
  end

  assign flag_o = flag_q;

endmodule

// File: rtl/bus_resp_timer.sv
module bus_resp_timer #(
  parameter int TICK_W      = 12,
  parameter int GAP_MIN_TK  = 100,
  parameter int RESP_MIN_TK = 40,
  parameter int RESP_MAX_TK = 400,
  parameter int NORESP_TK   = 800
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_i,
  input  logic              par_mid_i,
  input  logic              reply_due_i,
  input  logic              msg_end_i,
  input  logic              sync_mid_i,
  input  logic              sync_cmd_i,
  output logic              res_valid_o,
  output logic [1:0]        res_code_o,
  output logic              res_gap_o,
  output logic [TICK_W-1:0] res_ticks_o,
  output logic [3:0]        err_flags_o
);
  import brtm_pkg::*;

  localparam logic [TICK_W-1:0] NORESP_V = TICK_W'(NORESP_TK);

  arm_e              arm_q;
  arm_e              arm_d;
  logic [TICK_W-1:0] cnt;
  rc_e               cls_code;
  logic              cmd_sync;
  logic              evt_resp;
  logic              evt_tmo;
  logic              evt_gap;
  logic              evt_any;
  logic [FLAG_N-1:0] flag_set;
  logic [FLAG_N-1:0] flags;

  logic              res_valid_q;
  rc_e               res_code_q;
  rc_e               res_code_d;
  logic              res_gap_q;
  logic [TICK_W-1:0] res_ticks_q;

  brtm_tick_counter #(
    .W (TICK_W)
  ) u_cnt (
    .clk       (clk),
    .rst_n     (rst_n),
    .restart_i (par_mid_i),
    .run_i     (arm_q != ARM_IDLE),
    .cnt_o     (cnt)
  );

  brtm_window_class #(
    .W           (TICK_W),
    .GAP_MIN_TK  (GAP_MIN_TK),
    .RESP_MIN_TK (RESP_MIN_TK),
    .RESP_MAX_TK (RESP_MAX_TK)
  ) u_cls (
    .ticks_i (cnt),
    .gap_i   (arm_q == ARM_GAP),
    .code_o  (cls_code)
  );

  // closing events; a parity strobe in the same cycle overrides them
  always_comb begin
    cmd_sync = sync_mid_i && sync_cmd_i && !par_mid_i;
    evt_resp = (arm_q == ARM_RESP) && cmd_sync;
    evt_tmo  = (arm_q == ARM_RESP) && !cmd_sync && !par_mid_i && (cnt == NORESP_V);
    evt_gap  = (arm_q == ARM_GAP) && cmd_sync;
    evt_any  = evt_resp || evt_tmo || evt_gap;
  end

  always_comb begin
    arm_d = arm_q;
    if (par_mid_i) begin
      if (reply_due_i)    arm_d = ARM_RESP;
      else if (msg_end_i) arm_d = ARM_GAP;
      else                arm_d = ARM_IDLE;
    end else if (evt_any) begin
      arm_d = ARM_IDLE;
    end
  end

  always_comb begin
    res_code_d = evt_tmo ? RC_NORESP : cls_code;
    flag_set = '0;
    flag_set[FL_GAP]    = evt_gap && (cls_code == RC_EARLY);
    flag_set[FL_EARLY]  = evt_resp && (cls_code == RC_EARLY);
    flag_set[FL_LATE]   = evt_resp && (cls_code == RC_LATE);
    flag_set[FL_NORESP] = evt_tmo;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      arm_q       <= ARM_IDLE;
      res_valid_q <= 1'b0;
      res_code_q  <= RC_OK;
      res_gap_q   <= 1'b0;
      res_ticks_q <= '0;
    end else begin
      arm_q       <= arm_d;
      res_valid_q <= evt_any;
      if (evt_any) begin
        res_code_q  <= res_code_d;
        res_gap_q   <= evt_gap;
        res_ticks_q <= cnt;
      end
    end
  end

  brtm_sticky_flags #(
    .N (FLAG_N)
  ) u_flags (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr_i  (clr_i),
    .set_i  (flag_set),
    .flag_o (flags)
  );

  assign res_valid_o = res_valid_q;
  assign res_code_o  = res_code_q;
  assign res_gap_o   = res_gap_q;
  assign res_ticks_o = res_ticks_q;
  assign err_flags_o = flags;

  AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n) res_valid_q |=> !res_valid_q); // R2
  AST_NORESP_TICKS: assert property (@(posedge clk) disable iff (!rst_n) (res_valid_q && res_code_q == RC_NORESP) |-> (res_ticks_q == NORESP_V && !res_gap_q)); // R4
  AST_GAP_CODES: assert property (@(posedge clk) disable iff (!rst_n) (res_valid_q && res_gap_q) |-> (res_code_q == RC_OK || res_code_q == RC_EARLY)); // R5
  AST_LATE_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n) (res_valid_q && !res_gap_q && res_code_q == RC_LATE) |-> err_flags_o[FL_LATE]); // R6
  AST_NORESP_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n) (res_valid_q && res_code_q == RC_NORESP) |-> err_flags_o[FL_NORESP]); // R6

endmodule

// File: tb/bus_resp_timer_test.sv
module bus_resp_timer_test;

  localparam int TW = 12;

  logic          clk;
  logic          rst_n;
  logic          clr;
  logic          par;
  logic          reply;
  logic          mend;
  logic          sync;
  logic          scmd;
  logic          valid;
  logic [1:0]    code;
  logic          gap;
  logic [TW-1:0] ticks;
  logic [3:0]    err;

  int tests = 0;
  int fails = 0;
  bit done  = 0;

  bus_resp_timer uut (
    .clk         (clk),
    .rst_n       (rst_n),
    .clr_i       (clr),
    .par_mid_i   (par),
    .reply_due_i (reply),
    .msg_end_i   (mend),
    .sync_mid_i  (sync),
    .sync_cmd_i  (scmd),
    .res_valid_o (valid),
    .res_code_o  (code),
    .res_gap_o   (gap),
    .res_ticks_o (ticks),
    .err_flags_o (err)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  typedef struct packed {
    logic [11:0] n;     // 0 = no sync at all
    logic        rep;
    logic        me;
    logic [1:0]  xcode;
    logic        xgap;
    logic [11:0] xticks;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VECS [NV] = '{
    '{12'd40,  1'b1, 1'b0, 2'd0, 1'b0, 12'd40},   // R3 window low edge
    '{12'd39,  1'b1, 1'b0, 2'd1, 1'b0, 12'd39},   // R3 early
    '{12'd400, 1'b1, 1'b0, 2'd0, 1'b0, 12'd400},  // R3 window high edge
    '{12'd401, 1'b1, 1'b0, 2'd2, 1'b0, 12'd401},  // R3 late
    '{12'd800, 1'b1, 1'b0, 2'd2, 1'b0, 12'd800},  // R4 sync at timeout is late
    '{12'd1,   1'b1, 1'b0, 2'd1, 1'b0, 12'd1},    // R3 minimal interval
    '{12'd99,  1'b0, 1'b1, 2'd1, 1'b1, 12'd99},   // R5 short gap
    '{12'd100, 1'b0, 1'b1, 2'd0, 1'b1, 12'd100},  // R5 gap edge
    '{12'd250, 1'b0, 1'b1, 2'd0, 1'b1, 12'd250},  // R5 normal gap
    '{12'd0,   1'b1, 1'b0, 2'd3, 1'b0, 12'd800},  // R4 no response
    '{12'd150, 1'b1, 1'b0, 2'd0, 1'b0, 12'd150}   // R3 mid window
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic parity(input logic rep, input logic me);
    par = 1'b1; reply = rep; mend = me;
    @(negedge clk);
    par = 1'b0; reply = 1'b0; mend = 1'b0;
  endtask

  task automatic syncw(input logic c);
    sync = 1'b1; scmd = c;
    @(negedge clk);
    sync = 1'b0; scmd = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      tests++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic seen;
    rst_n = 1'b0; clr = 1'b0; par = 1'b0; reply = 1'b0; mend = 1'b0; sync = 1'b0; scmd = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 valid", {31'd0, valid}, 32'd0);
    chk("R1 code", {30'd0, code}, 32'd0);
    chk("R1 gap", {31'd0, gap}, 32'd0);
    chk("R1 ticks", {20'd0, ticks}, 32'd0);
    chk("R1 flags", {28'd0, err}, 32'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // table walk: R2 R3 R4 R5
    for (int i = 0; i < NV; i++) begin
      parity(VECS[i].rep, VECS[i].me);
      if (VECS[i].n == 12'd0) begin
        repeat (800) @(negedge clk);
      end else begin
        repeat (int'(VECS[i].n) - 1) @(negedge clk);
        syncw(1'b1);
      end
      chk($sformatf("R2 valid vec%0d", i), {31'd0, valid}, 32'd1);
      chk($sformatf("R3 code vec%0d", i), {30'd0, code}, {30'd0, VECS[i].xcode});
      chk($sformatf("R5 kind vec%0d", i), {31'd0, gap}, {31'd0, VECS[i].xgap});
      chk($sformatf("R2 ticks vec%0d", i), {20'd0, ticks}, {20'd0, VECS[i].xticks});
      @(negedge clk);
      chk($sformatf("R2 pulse width vec%0d", i), {31'd0, valid}, 32'd0);
      repeat (3) @(negedge clk);
    end

    chk("R6 all flags sticky", {28'd0, err}, 32'hF);
    clr = 1'b1;
    @(negedge clk);
    clr = 1'b0;
    chk("R7 clear", {28'd0, err}, 32'h0);

    // R8: parity overtakes a pending response; unqualified parity arms nothing
    parity(1'b1, 1'b0);
    repeat (100) @(negedge clk);
    parity(1'b0, 1'b0);
    seen = 1'b0;
    repeat (29) begin
      seen |= valid;
      @(negedge clk);
    end
    syncw(1'b1);
    repeat (900) begin
      seen |= valid;
      @(negedge clk);
    end
    chk("R8 no result after restart", {31'd0, seen}, 32'd0);
    chk("R8 no flags after restart", {28'd0, err}, 32'h0);

    // R9: data sync ignored during response wait
    parity(1'b1, 1'b0);
    repeat (49) @(negedge clk);
    syncw(1'b0);
    chk("R9 data sync no result", {31'd0, valid}, 32'd0);
    repeat (149) @(negedge clk);
    syncw(1'b1);
    chk("R9 valid after data sync", {31'd0, valid}, 32'd1);
    chk("R9 ticks after data sync", {20'd0, ticks}, 32'd200);
    chk("R9 code ok", {30'd0, code}, 32'd0);
    chk("R9 flags untouched", {28'd0, err}, 32'h0);

    // R6: single flag set by a late response, then held
    repeat (3) @(negedge clk);
    parity(1'b1, 1'b0);
    repeat (499) @(negedge clk);
    syncw(1'b1);
    chk("R6 late code", {30'd0, code}, 32'd2);
    chk("R6 late flag only", {28'd0, err}, 32'h4);
    repeat (20) @(negedge clk);
    chk("R6 late flag held", {28'd0, err}, 32'h4);

    // R7: set wins over a simultaneous clear (no-response on the clearing edge)
    parity(1'b1, 1'b0);
    repeat (799) @(negedge clk);
    clr = 1'b1;
    @(negedge clk);
    clr = 1'b0;
    chk("R4 timeout code", {30'd0, code}, 32'd3);
    chk("R7 set beats clear", {28'd0, err}, 32'h8);

    // R10: very long gap saturates
    repeat (3) @(negedge clk);
    parity(1'b0, 1'b1);
    repeat (4199) @(negedge clk);
    syncw(1'b1);
    chk("R10 saturated ticks", {20'd0, ticks}, 32'd4095);
    chk("R10 code ok", {30'd0, code}, 32'd0);
    chk("R10 gap kind", {31'd0, gap}, 32'd1);

    // R1: reset mid-operation clears everything
    rst_n = 1'b0;
    @(negedge clk);
    chk("R1 flags after reset", {28'd0, err}, 32'h0);
    chk("R1 ticks after reset", {20'd0, ticks}, 32'd0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule